// File: doc/BRIEF.md
# Block Floating-Point Scaling Controller

This controller sits beside the radix-2 butterfly of an in-place FFT engine and decides, pass by pass, whether the data feeding the next pass should be shifted right by one bit. It watches every butterfly result that carries a valid strobe. At the end of the pass it turns what it saw into a single shift decision. That decision is held steady for the whole of the following pass, so the engine can apply it at the butterfly inputs.

Two policies are offered. The growth-driven policy (mode 0) shifts only when at least one result of the finished pass has grown into its guard bit. The fixed policy (mode 1) shifts after every computational pass, so a transform of log2 N passes ends scaled by 1/N. The raw input frame can be swept as an extra pass, marked by a pre-check flag, before the first computational pass. Under the growth-driven policy that sweep halves the frame when needed. Under the fixed policy it never shifts. A running block exponent counts every shift granted since the frame began, so the true magnitude of the result is the output times two to that exponent.

Top module: `bfp_scale_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `shift_next` and `blk_exp` become 0 after that edge.
- R2: A valid sample counts as grown when bit DATA_W-1 differs from bit DATA_W-2 in its real part, its imaginary part, or both. In other words, it is grown when either part lies outside the range -2^(DATA_W-2) to 2^(DATA_W-2)-1.
- R3: In mode 0, on the edge where `pass_end` is high, `shift_next` becomes 1 exactly when a grown valid sample arrived on some edge of the pass. The pass runs from the `pass_start` edge up to and including the `pass_end` edge.
- R4: A sample presented with `smp_valid` low has no effect on any later shift decision.
- R5: `pass_start` discards growth seen before it. A grown sample on the `pass_start` edge itself does count.
- R6: On edges without `pass_end` or `frame_start`, `shift_next` and `blk_exp` keep their values.
- R7: In mode 1, a `pass_end` with `pre_check` low makes `shift_next` 1 whatever the data.
- R8: A `pass_end` with `pre_check` high follows R3 in mode 0 and always gives `shift_next` = 0 in mode 1.
- R9: Each `pass_end` that sets `shift_next` to 1 adds one to `blk_exp`, which saturates at 2^EXP_W-1. Here EXP_W = clog2(MAX_PASSES+2).
- R10: `frame_start` clears `shift_next`, `blk_exp` and the growth history. It takes priority over `pass_end` on the same edge.
- R11: `mode` matters only on the `pass_end` edge. A mode change in the middle of a pass does not affect the decision taken at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = growth-driven scaling, 1 = shift every pass |
| frame_start | input | 1 | Begin a new frame; clears exponent and decision |
| pass_start | input | 1 | First edge of a pass; clears growth history |
| pass_end | input | 1 | Last edge of a pass; decision is latched here |
| pre_check | input | 1 | High during the input sweep that precedes pass one |
| smp_valid | input | 1 | Butterfly result on `smp_re`/`smp_im` is valid |
| smp_re | input | DATA_W | Real part of the result, two's complement |
| smp_im | input | DATA_W | Imaginary part of the result, two's complement |
| shift_next | output | 1 | Shift the next pass's inputs right by one bit |
| blk_exp | output | EXP_W | Shifts accumulated in the current frame |

## Verification
The stimulus aims at the edges of the guard-bit test: the values just inside and just outside the safe range on both signs, and growth in the imaginary part only. A design that tested the wrong bit pair, or only the real part, would miss or invent a shift. Growth placed just before `pass_start`, on it, and on the `pass_end` edge itself exposes a flag cleared one cycle late or a decision that drops the final sample. Invalid grown samples, a mode flip in mid-pass, a pre-check sweep under both policies, `frame_start` colliding with `pass_end`, and a long run of fixed-policy passes cover the rest. A counter that wraps instead of saturating, or a frame clear that loses to a pass end, would show up as a wrong exponent.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    typedef enum logic {
        BFP_GROWTH = 1'b0,
        BFP_ALWAYS = 1'b1
    } bfp_mode_e;

    // Width of a counter that must hold every shift of a frame plus the pre-check.
    function automatic int exp_width(input int max_passes);
        return $clog2(max_passes + 2);
    endfunction

    // True when the sign bit and the guard bit below it disagree.
    function automatic logic guard_breached(input logic [1:0] top);
        return top[1] ^ top[0];
    endfunction

    typedef struct packed {
        logic shift;
        logic counts;
    } bfp_decision_t;

endpackage

// File: rtl/bfp_growth_detect.sv
module bfp_growth_detect
    import bfp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] re,
    input  logic [DATA_W-1:0] im,
    output logic              grown
);
    localparam int PARTS = 2;

    logic [PARTS-1:0][DATA_W-1:0] parts;
    logic [PARTS-1:0]             breach;

    assign parts[0] = re;
    assign parts[1] = im;

    for (genvar p = 0; p < PARTS; p++) begin : g_part
        assign breach[p] = guard_breached(parts[p][DATA_W-1 -: 2]);
    end

    assign grown = valid & (|breach);

endmodule

// File: rtl/bfp_growth_flag.sv
module bfp_growth_flag (
    input  logic clk,
    input  logic rst,
    input  logic clear_all,
    input  logic pass_start,
    input  logic grown,
    output logic pass_any
);
    logic flag_q;

    // Growth seen so far in the current pass, including this edge.
    assign pass_any = (pass_start ? 1'b0 : flag_q) | grown;

    always_ff @(posedge clk) begin
        if (rst || clear_all) flag_q <= 1'b0;
        else                  flag_q <= pass_any;
    end

    p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (pass_start && !grown && !clear_all) |=> !flag_q);

endmodule

// File: rtl/bfp_exp_acc.sv
module bfp_exp_acc #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [EXP_W-1:0] exp_q
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)                  exp_q <= '0;
        else if (bump && exp_q != EXP_MAX) exp_q <= exp_q + 1'b1;
    end

    p_exp_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!clear && bump && $past(1'b1)) |=>
            (exp_q == $past(exp_q) + 1'b1) || (exp_q == EXP_MAX));

    p_exp_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!clear && !bump) |=> $stable(exp_q));

endmodule

// File: rtl/bfp_scale_ctrl.sv
module bfp_scale_ctrl
    import bfp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MAX_PASSES = 11,
    parameter int EXP_W      = exp_width(MAX_PASSES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              frame_start,
    input  logic              pass_start,
    input  logic              pass_end,
    input  logic              pre_check,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_re,
    input  logic [DATA_W-1:0] smp_im,
    output logic              shift_next,
    output logic [EXP_W-1:0]  blk_exp
);
    bfp_mode_e     mode_e;
    logic          grown;
    logic          pass_any;
    bfp_decision_t dec;
    logic          shift_q;

    assign mode_e = bfp_mode_e'(mode);

    bfp_growth_detect #(.DATA_W(DATA_W)) u_detect (
        .valid (smp_valid),
        .re    (smp_re),
        .im    (smp_im),
        .grown (grown)
    );

    bfp_growth_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .clear_all  (frame_start),
        .pass_start (pass_start),
        .grown      (grown),
        .pass_any   (pass_any)
    );

    always_comb begin
        dec.counts = pass_end && !frame_start;
        unique case (mode_e)
            BFP_GROWTH: dec.shift = pass_any;
            BFP_ALWAYS: dec.shift = !pre_check;
            default:    dec.shift = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) shift_q <= 1'b0;
        else if (dec.counts)    shift_q <= dec.shift;
    end

    bfp_exp_acc #(.EXP_W(EXP_W)) u_exp (
        .clk   (clk),
        .rst   (rst),
        .clear (frame_start),
        .bump  (dec.counts && dec.shift),
        .exp_q (blk_exp)
    );

    assign shift_next = shift_q;

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!pass_end && !frame_start) |=> $stable(shift_next));

    p_always_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (pass_end && !frame_start && mode && !pre_check) |=> shift_next);

    p_precheck_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (pass_end && !frame_start && mode && pre_check) |=> !shift_next);

    p_frame_clear_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!shift_next && blk_exp == '0));

    p_growth_end_r3: assert property (@(posedge clk) disable iff (rst)
        (pass_end && !frame_start && !mode && smp_valid &&
         (smp_re[DATA_W-1] != smp_re[DATA_W-2])) |=> shift_next);

endmodule

// File: tb/bfp_scale_ctrl_tb.sv
module bfp_scale_ctrl_tb;
    localparam int DATA_W     = 16;
    localparam int MAX_PASSES = 11;
    localparam int EXP_W      = $clog2(MAX_PASSES + 2);
    localparam int EXP_MAX    = (1 << EXP_W) - 1;
    localparam int LIM        = 1 << (DATA_W - 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0, frame_start = 1'b0, pass_start = 1'b0, pass_end = 1'b0;
    logic pre_check = 1'b0, smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_re = '0, smp_im = '0;
    logic shift_next;
    logic [EXP_W-1:0] blk_exp;

    always #5 clk = ~clk;

    bfp_scale_ctrl #(.DATA_W(DATA_W), .MAX_PASSES(MAX_PASSES)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .frame_start(frame_start),
        .pass_start(pass_start), .pass_end(pass_end), .pre_check(pre_check),
        .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
        .shift_next(shift_next), .blk_exp(blk_exp)
    );

    int checks = 0, errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Reference state
    int ref_shift = 0, ref_exp = 0;
    bit ref_seen = 1'b0;

    function automatic bit outside(input logic [DATA_W-1:0] v);
        int s;
        s = int'($signed(v));
        return (s < -LIM) || (s > LIM - 1);
    endfunction

    task automatic compare();
        checks++;
        if (shift_next !== ref_shift[0] || blk_exp !== EXP_W'(ref_exp)) begin
            errors++;
            $display("FAIL %s: shift_next=%0b blk_exp=%0d expected shift_next=%0d blk_exp=%0d",
                     tag, shift_next, blk_exp, ref_shift, ref_exp);
        end
    endtask

    // One cycle: check outputs, drive inputs, advance the reference.
    task automatic cyc(input bit r, input bit fs, input bit ps, input bit pe,
                       input bit pc, input bit md, input bit v,
                       input logic [DATA_W-1:0] re, input logic [DATA_W-1:0] im);
        bit g, any, d;
        @(negedge clk);
        compare();
        rst = r; frame_start = fs; pass_start = ps; pass_end = pe;
        pre_check = pc; mode = md; smp_valid = v; smp_re = re; smp_im = im;
        g   = v && (outside(re) || outside(im));
        any = (ps ? 1'b0 : ref_seen) | g;
        if (r || fs) begin
            ref_shift = 0; ref_exp = 0; ref_seen = 1'b0;
        end else begin
            if (pe) begin
                d = md ? !pc : any;
                ref_shift = d;
                if (d && ref_exp < EXP_MAX) ref_exp++;
            end
            ref_seen = any;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, mode, 0, '0, '0);
    endtask

    // A pass: clean sample on start, n clean samples, then a final sample on end.
    task automatic pass(input bit md, input bit pc, input int n,
                        input logic [DATA_W-1:0] re_end, input logic [DATA_W-1:0] im_end);
        cyc(0, 0, 1, 0, pc, md, 1, 16'h0100, 16'hFF00);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, pc, md, 1, 16'(i * 37), 16'(-i * 53));
        cyc(0, 0, 0, 1, pc, md, 1, re_end, im_end);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        cyc(1, 0, 0, 0, 0, 0, 0, '0, '0);
        cyc(1, 0, 0, 0, 0, 0, 0, '0, '0);
        cyc(0, 1, 0, 0, 0, 0, 0, '0, '0);
        // R2: guard bit test boundaries
        tag = "R2";
        pass(0, 0, 3, 16'h4000, 16'h0000); idle(1);   // +LIM grown
        pass(0, 0, 3, 16'h3FFF, 16'h0000); idle(1);   // +LIM-1 clean
        pass(0, 0, 3, 16'hC000, 16'hC000); idle(1);   // -LIM clean
        pass(0, 0, 3, 16'hBFFF, 16'h0000); idle(1);   // -LIM-1 grown
        pass(0, 0, 3, 16'h0000, 16'h8000); idle(1);   // imaginary only grown
        // R3: growth in the middle of a pass, long pass
        tag = "R3";
        cyc(0, 0, 1, 0, 0, 0, 1, 16'h0010, 16'h0010);
        cyc(0, 0, 0, 0, 0, 0, 1, 16'h7000, 16'h0000);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 1, 16'h0001, 16'h0001);
        cyc(0, 0, 0, 1, 0, 0, 1, 16'h0002, 16'h0002);
        idle(2);
        pass(0, 0, 8, 16'h0123, 16'hFEDC); idle(1);
        // R4: invalid grown samples ignored
        tag = "R4";
        cyc(0, 0, 1, 0, 0, 0, 0, 16'h7FFF, 16'h8000);
        cyc(0, 0, 0, 0, 0, 0, 0, 16'h4000, 16'h4000);
        cyc(0, 0, 0, 1, 0, 0, 0, 16'h8000, 16'h7FFF);
        idle(2);
        // R5: growth before start discarded, growth on start counted
        tag = "R5";
        cyc(0, 0, 0, 0, 0, 0, 1, 16'h6000, 16'h0000);
        pass(0, 0, 2, 16'h0000, 16'h0000); idle(1);
        cyc(0, 0, 1, 0, 0, 0, 1, 16'h0000, 16'hA000);
        cyc(0, 0, 0, 1, 0, 0, 1, 16'h0000, 16'h0000);
        // R6: hold across idle cycles
        tag = "R6";
        idle(5);
        // R11: mode flips in mid-pass
        tag = "R11";
        cyc(0, 0, 1, 0, 0, 1, 1, 16'h0000, 16'h0000);
        cyc(0, 0, 0, 0, 0, 1, 1, 16'h0000, 16'h0000);
        cyc(0, 0, 0, 1, 0, 0, 1, 16'h0000, 16'h0000);   // decided by mode 0
        idle(1);
        cyc(0, 0, 1, 0, 0, 0, 1, 16'h0000, 16'h0000);
        cyc(0, 0, 0, 1, 0, 1, 1, 16'h0000, 16'h0000);   // decided by mode 1
        idle(1);
        // R8: pre-check sweep under both policies
        tag = "R8";
        cyc(0, 1, 0, 0, 0, 0, 0, '0, '0);
        pass(0, 1, 4, 16'h5000, 16'h0000); idle(1);
        pass(0, 1, 4, 16'h1000, 16'h0000); idle(1);
        pass(1, 1, 4, 16'h5000, 16'h5000); idle(1);
        // R7: fixed policy shifts clean data
        tag = "R7";
        cyc(0, 1, 0, 0, 0, 1, 0, '0, '0);
        for (int k = 0; k < 5; k++) pass(1, 0, 2, 16'h0000, 16'h0000);
        idle(1);
        // R9: saturation of the exponent
        tag = "R9";
        for (int k = 0; k < EXP_MAX + 4; k++) pass(1, 0, 1, 16'h0001, 16'h0001);
        idle(2);
        // R10: frame start wins over pass end
        tag = "R10";
        cyc(0, 0, 1, 0, 0, 1, 1, 16'h0000, 16'h0000);
        cyc(0, 1, 0, 1, 0, 1, 1, 16'h7FFF, 16'h7FFF);
        idle(2);
        pass(0, 0, 2, 16'h4000, 16'h0000);
        cyc(0, 1, 0, 0, 0, 0, 0, '0, '0);
        idle(2);
        // R1: reset again after activity
        tag = "R1";
        pass(1, 0, 1, 16'h0000, 16'h0000);
        cyc(1, 0, 0, 0, 0, 0, 0, '0, '0);
        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s: run hung, expected completion", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule